// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a three-wire serial EEPROM holding 256 words of 16 bits. A host drives a chip select, a serial clock and a data input, and reads a data output. All of these are sampled by the block's own system clock. Each command begins with a start bit. It then carries a two-bit opcode, an eight-bit word address and, for a write, sixteen data bits. The block decodes read, write, erase, write-enable and write-disable commands.

Reads stream words back to back and advance the address on their own for as long as chip select stays high. Writes and erases are armed when their last bit arrives. A self-timed programming cycle starts when chip select falls. While that cycle runs, the block reports busy or ready on the data output whenever chip select is high. The block comes out of reset write-protected. The storage array is a register file inside the block.

Top module: `mw_eeprom`

## Requirements
- R1: Command bits are taken on rising serial-clock edges: a start bit of 1, then the opcode MSB first (10 read, 01 write, 11 erase, 00 extended), then the 8-bit address MSB first.
- R2: Chip select low returns the block to idle and discards any partly received command or read in progress.
- R3: While chip select is high and no start bit has arrived, serial-clock edges with data input 0 change nothing.
- R4: A write is carried out only if all 16 data bits have arrived before chip select falls; a shorter command leaves memory unchanged and starts no programming cycle.
- R5: A complete write stores its 16-bit word, sent MSB first, at the addressed location when chip select falls. An erase stores 0xFFFF there.
- R6: Once started, a programming cycle completes even while chip select is low.
- R7: After reset, writes and erases are ignored. Extended opcode 00 with address bits [7:6] = 11 enables them, and with [7:6] = 00 disables them again.
- R8: A read first outputs one 0 bit. It then outputs 16 data bits MSB first, and continues with the following words while chip select stays high, wrapping from address 255 to 0.
- R9: Programming lasts PROG_CYCLES system clocks. During it, serial clocks and start bits are ignored, and with chip select high the data output reads 0 (busy), then 1 (ready) after completion.
- R10: `sdo_en` is high only while chip select is high and either a read is streaming or a programming status is being shown.
- R11: After reset every word holds 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data / ready-busy status to host |
| sdo_en | output | 1 | High when `sdo` is being driven |

## Verification
The hardest situation to reach is a host that starts a new command while a programming cycle is still running. The stimulus raises chip select a few system clocks after the falling edge that started programming. It then clocks in a start bit and opcode bits, and checks that the output still shows busy and that no read begins. The stimulus also drops chip select partway through a streaming read and partway through the data phase of a write. After each of these it issues a fresh command to show that nothing was kept.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_ARMED,
        ST_RDOUT,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;
endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic sdi,
    output logic cs_s,
    output logic sdi_s,
    output logic sk_rise,
    output logic cs_fall
);
    typedef struct packed {
        logic cs_s;
        logic cs_p;
        logic sk_s;
        logic sk_p;
        logic sdi_s;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.cs_s  = cs;
        r_d.cs_p  = r_q.cs_s;
        r_d.sk_s  = sk;
        r_d.sk_p  = r_q.sk_s;
        r_d.sdi_s = sdi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cs_s    = r_q.cs_s;
    assign sdi_s   = r_q.sdi_s;
    assign sk_rise = r_q.sk_s & ~r_q.sk_p;
    assign cs_fall = ~r_q.cs_s & r_q.cs_p;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start && cnt_q == '0) cnt_d = CW'(PROG_CYCLES);
        else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    p_we_addr_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr) && !$isunknown(wdata));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    import mw_pkg::*;

    localparam int CMDW = 2 + AW;
    localparam int DCW  = $clog2(DW);
    localparam int MAXB = (DW > CMDW) ? DW : CMDW;
    localparam int BCW  = $clog2(MAXB);

    typedef struct packed {
        mw_state_e     st;
        logic [BCW-1:0] bcnt;
        logic [CMDW-1:0] csr;
        logic [DW-1:0]  dsr;
        logic [AW-1:0]  addr;
        logic           wen;
        logic [DW-1:0]  rbuf;
        logic [DCW-1:0] rcnt;
        logic           rbit;
        logic           stat;
        logic [AW-1:0]  paddr;
        logic [DW-1:0]  pdata;
    } regs_t;

    regs_t r_q, r_d;

    logic cs_s, sdi_s, sk_rise, cs_fall;
    logic busy, done, prog_go;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [CMDW-1:0] cmd_word;

    mw_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .sdi     (sdi),
        .cs_s    (cs_s),
        .sdi_s   (sdi_s),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_go),
        .busy  (busy),
        .done  (done)
    );

    mw_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (done),
        .waddr (r_q.paddr),
        .wdata (r_q.pdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign cmd_word = {r_q.csr[CMDW-2:0], sdi_s};

    // Read port: the decoded address on the last command bit, else the next word.
    always_comb begin
        if (r_q.st == ST_CMD) rd_addr = cmd_word[AW-1:0];
        else                  rd_addr = r_q.addr + 1'b1;
    end

    always_comb begin
        r_d     = r_q;
        prog_go = 1'b0;
        if (!cs_s) begin
            r_d.st   = ST_IDLE;
            r_d.bcnt = '0;
            if (cs_fall && !busy) begin
                if (r_q.st == ST_ARMED && r_q.wen) begin
                    prog_go  = 1'b1;
                    r_d.stat = 1'b1;
                end else begin
                    r_d.stat = 1'b0;
                end
            end
        end else if (sk_rise && !busy) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (sdi_s) begin
                        r_d.st   = ST_CMD;
                        r_d.bcnt = '0;
                        r_d.stat = 1'b0;
                    end
                end
                ST_CMD: begin
                    r_d.csr  = cmd_word;
                    r_d.bcnt = r_q.bcnt + 1'b1;
                    if (r_q.bcnt == BCW'(CMDW - 1)) begin
                        r_d.bcnt = '0;
                        r_d.addr = cmd_word[AW-1:0];
                        unique case (cmd_word[CMDW-1 -: 2])
                            OP_READ: begin
                                r_d.rbuf = rd_data;
                                r_d.rcnt = '0;
                                r_d.rbit = 1'b0;
                                r_d.st   = ST_RDOUT;
                            end
                            OP_WRITE: begin
                                r_d.paddr = cmd_word[AW-1:0];
                                r_d.st    = ST_DATA;
                            end
                            OP_ERASE: begin
                                r_d.paddr = cmd_word[AW-1:0];
                                r_d.pdata = '1;
                                r_d.st    = ST_ARMED;
                            end
                            default: begin
                                if (cmd_word[AW-1 -: 2] == EXT_ENABLE)  r_d.wen = 1'b1;
                                if (cmd_word[AW-1 -: 2] == EXT_DISABLE) r_d.wen = 1'b0;
                                r_d.st = ST_HOLD;
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    r_d.dsr  = {r_q.dsr[DW-2:0], sdi_s};
                    r_d.bcnt = r_q.bcnt + 1'b1;
                    if (r_q.bcnt == BCW'(DW - 1)) begin
                        r_d.pdata = {r_q.dsr[DW-2:0], sdi_s};
                        r_d.bcnt  = '0;
                        r_d.st    = ST_ARMED;
                    end
                end
                ST_RDOUT: begin
                    r_d.rbit = r_q.rbuf[DW-1];
                    if (r_q.rcnt == DCW'(DW - 1)) begin
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.rbuf = rd_data;
                        r_d.rcnt = '0;
                    end else begin
                        r_d.rbuf = {r_q.rbuf[DW-2:0], 1'b0};
                        r_d.rcnt = r_q.rcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_en = cs_s && (r_q.stat || r_q.st == ST_RDOUT);
    assign sdo    = r_q.stat ? ~busy : r_q.rbit;

    p_prog_from_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.st) == ST_ARMED && !cs_s);
    p_prog_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.wen));
    p_frozen_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(r_q.paddr) && $stable(r_q.pdata));
    p_active_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st != ST_IDLE |-> $past(cs_s));
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
    localparam int PROG = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_en;

    int n_chk = 0;
    int n_fail = 0;
    int model [256];
    bit model_wen = 1'b0;

    always #2.5 clk = ~clk;

    mw_eeprom #(.AW(8), .DW(16), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdi = b;
        idle(2);
        sk = 1'b1;
        idle(4);
        sk = 1'b0;
        idle(4);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] a, input int pre);
        cs = 1'b1;
        idle(3);
        for (int i = 0; i < pre; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = 7; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic ext(input logic [7:0] a);
        send_cmd(2'b00, a, 0);
        cs = 1'b0;
        idle(4);
        if (a[7:6] == 2'b11) model_wen = 1'b1;
        if (a[7:6] == 2'b00) model_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int words, input int pre, input string req);
        send_cmd(2'b10, a, pre);
        chk({req, " dummy"}, sdo, 0);
        chk({req, " en"}, sdo_en, 1);
        for (int w = 0; w < words; w++) begin
            logic [15:0] word = '0;
            for (int b = 0; b < 16; b++) begin
                pulse(1'b0);
                word = {word[14:0], sdo};
            end
            chk(req, word, model[(a + w) % 256]);
        end
        cs = 1'b0;
        idle(4);
    endtask

    // Write (erase when er=1), then check status output.
    task automatic prog(input logic [7:0] a, input logic [15:0] d, input bit er, input string req);
        send_cmd(er ? 2'b11 : 2'b01, a, 0);
        if (!er) for (int i = 15; i >= 0; i--) pulse(d[i]);
        cs = 1'b0;
        idle(4);
        cs = 1'b1;
        idle(4);
        if (model_wen) begin
            model[a] = er ? 16'hFFFF : d;
            chk({req, " busy R9"}, {sdo_en, sdo}, 2'b10);
            idle(PROG + 8);
            chk({req, " ready R9"}, {sdo_en, sdo}, 2'b11);
        end else begin
            chk({req, " no status R7"}, sdo_en, 0);
        end
        cs = 1'b0;
        idle(4);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
        idle(5);
        rst_n = 1'b1;
        idle(3);

        chk("R10 reset en", sdo_en, 0);
        rd(8'd0, 1, 0, "R11 reset word");

        prog(8'd5, 16'h1234, 0, "R7 write while protected");
        rd(8'd5, 1, 0, "R7 protected");

        ext(8'hC0);
        // R10: output stays off while a write command is shifted in
        send_cmd(2'b01, 8'd5, 0);
        chk("R10 en during input", sdo_en, 0);
        for (int i = 15; i >= 0; i--) pulse(16'hA5C3 >> i);
        cs = 1'b0;
        idle(4);
        model[5] = 16'hA5C3;
        // R6: chip select stays low for the whole cycle
        idle(PROG + 8);
        rd(8'd5, 1, 0, "R5 R6 write completes with cs low");

        prog(8'd255, 16'h8001, 0, "R5 w255");
        prog(8'd0, 16'h7E11, 0, "R5 w0");
        prog(8'd1, 16'h0F0F, 0, "R5 w1");
        rd(8'd254, 4, 0, "R8 sequential wrap");

        prog(8'd5, 16'h0, 1, "R5 erase");
        rd(8'd5, 1, 0, "R5 erased");

        // R4: write cut short after 10 data bits
        send_cmd(2'b01, 8'd9, 0);
        for (int i = 0; i < 10; i++) pulse(1'b0);
        cs = 1'b0;
        idle(4);
        cs = 1'b1;
        idle(4);
        chk("R4 no programming", sdo_en, 0);
        cs = 1'b0;
        idle(PROG + 8);
        rd(8'd9, 1, 0, "R4 short write dropped");

        // R3: idle clocks before the start bit
        rd(8'd0, 1, 5, "R3 leading zeros ignored");

        // R2: abort a read midway
        send_cmd(2'b10, 8'd255, 0);
        for (int i = 0; i < 5; i++) pulse(1'b0);
        cs = 1'b0;
        idle(4);
        chk("R2 en after abort", sdo_en, 0);
        rd(8'd1, 1, 0, "R2 fresh read after abort");

        // R9: command attempted while programming
        send_cmd(2'b01, 8'd7, 0);
        for (int i = 15; i >= 0; i--) pulse(16'h3C3C >> i);
        cs = 1'b0;
        idle(3);
        model[7] = 16'h3C3C;
        cs = 1'b1;
        pulse(1'b1);
        pulse(1'b1);
        pulse(1'b0);
        chk("R9 busy ignores command", {sdo_en, sdo}, 2'b10);
        idle(PROG);
        chk("R9 ready after cycle", {sdo_en, sdo}, 2'b11);
        cs = 1'b0;
        idle(4);
        rd(8'd7, 1, 0, "R9 R1 write while ignoring");

        ext(8'h00);
        prog(8'd7, 16'h1111, 0, "R7 after disable");
        rd(8'd7, 1, 0, "R7 disabled write ignored");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule